// File: doc/BRIEF.md
# Serial DAC Command Front End

This block is the digital side of a 12-bit voltage-output converter. A host writes 16-bit command words over a three-wire serial link made of an active-low select, a data line and a serial clock. The block samples those pins on its own system clock, assembles each frame and decodes a four-bit command. It then either loads a new output code or changes the power state of the output stage.

Three outputs drive the analog stage. The first is the 12-bit code; the ideal output voltage is the supply times the code divided by 4096. The second is a flag that is high while the stage is powered. The third is a two-bit termination select that says how the output pin is terminated while the stage is powered down.

Waking up restores the code that was last loaded; the code is not cleared. A frame is acted on only if it holds exactly 16 bits, so a host that aborts a transfer part-way leaves the block unchanged.

Top module: `serdac_front`

## Requirements
- R1: A frame is sent MSB first. The first four bits received are the command (C3..C0). The last twelve bits are the data field, with D11 first.
- R2: Command 0000 copies the data field into `code_o`, sets `active_o` to 1 and sets `term_o` to 00. This applies whether or not the block was powered down.
- R3: Command 1111 with data bits [1:0] = 00 is a wake-up. It sets `active_o` to 1 and `term_o` to 00, leaves `code_o` unchanged and ignores data bits [11:2].
- R4: Command 1111 with data bits [1:0] = 01 powers the stage down with the output floating. `active_o` goes to 0, `term_o` goes to 01 and `code_o` is unchanged.
- R5: Command 1111 with data bits [1:0] = 10 powers down with `term_o` = 10 (low-value resistor to ground). Data bits [1:0] = 11 powers down with `term_o` = 11 (high-value resistor to ground). In both cases `code_o` is unchanged.
- R6: After reset, `code_o` is 0, `active_o` is 1 and `term_o` is 00.
- R7: A data bit is captured only on a falling edge of `sclk_i` while `cs_n_i` is low. Clock activity while `cs_n_i` is high has no effect.
- R8: A frame is acted on when `cs_n_i` rises after exactly 16 captured bits. A frame with fewer or more bits changes nothing.
- R9: A 16-bit frame whose command is neither 0000 nor 1111 changes neither `code_o`, `active_o` nor `term_o`.
- R10: `active_o` is 1 exactly when `term_o` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Serial select, active low, asynchronous to `clk` |
| sclk_i | input | 1 | Serial clock; data is captured on its falling edge |
| din_i | input | 1 | Serial data, MSB first |
| code_o | output | 12 | Output code held for the converter |
| active_o | output | 1 | 1 = output stage powered, 0 = powered down |
| term_o | output | 2 | 00 driven, 01 floating, 10 low-value resistor to ground, 11 high-value resistor to ground |

## Verification
The hardest case to reach from the ports is a frame with the wrong length whose bits would still decode as a valid load. It takes a select that stays low across an exact bit count other than 16, with the contents of the shift register lined up so that the only protection is the length check. The bench builds such frames for every length from 1 to 15 and from 17 to 20. The last 16 bits of each long frame form a legal load of a new code, and each short frame is the start of one. The bench then sweeps all 16 commands against all four low-bit patterns, starting from both a powered and a powered-down state, and checks every result against an arithmetic model of the command table.

// File: rtl/serdac_pkg.sv
package serdac_pkg;

  localparam int CMD_BITS = 4;

  typedef enum logic [1:0] {
    TERM_DRIVEN = 2'b00,
    TERM_OPEN   = 2'b01,
    TERM_LOW_R  = 2'b10,
    TERM_HIGH_R = 2'b11
  } term_t;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_WAKE  = 2'd2,
    OP_SLEEP = 2'd3
  } op_t;

  // Command table: the prefix picks load or power control; for power
  // control the two lowest data bits pick the termination.
  function automatic op_t decode_op(input logic [CMD_BITS-1:0] cmd,
                                    input logic [1:0] low);
    op_t op;
    op = OP_NONE;
    if (cmd == '0)
      op = OP_LOAD;
    else if (cmd == '1)
      op = (low == 2'b00) ? OP_WAKE : OP_SLEEP;
    return op;
  endfunction

  function automatic term_t term_of(input logic [1:0] low);
    return term_t'(low);
  endfunction

endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
  parameter int             WIDTH     = 3,
  parameter int             STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          chain[s] <= RESET_VAL;
        else if (s == 0)
          chain[s] <= async_i;
        else
          chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/serdac_deser.sv
module serdac_deser #(
  parameter int FRAME_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n_s,
  input  logic                  sclk_s,
  input  logic                  din_s,
  output logic [FRAME_BITS-1:0] word_o,
  output logic                  frame_end_o,
  output logic                  frame_full_o
);

  localparam int CNT_W   = $clog2(FRAME_BITS + 2);
  localparam int CNT_MAX = FRAME_BITS + 1;

  logic             cs_n_q;
  logic             sclk_q;
  logic [CNT_W-1:0] bit_cnt;
  logic             cs_fall;
  logic             sclk_fall;

  assign cs_fall     = cs_n_q & ~cs_n_s;
  assign frame_end_o = ~cs_n_q & cs_n_s;
  assign sclk_fall   = sclk_q & ~sclk_s & ~cs_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_n_q <= cs_n_s;
      sclk_q <= sclk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      word_o  <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
    end else if (sclk_fall) begin
      word_o <= {word_o[FRAME_BITS-2:0], din_s};
      if (bit_cnt != CNT_W'(CNT_MAX))
        bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign frame_full_o = (bit_cnt == CNT_W'(FRAME_BITS));

endmodule

// File: rtl/serdac_ctrl.sv
module serdac_ctrl
  import serdac_pkg::*;
#(
  parameter int CODE_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_ok,
  input  op_t                  op,
  input  logic [CODE_BITS-1:0] data,
  output logic [CODE_BITS-1:0] code_o,
  output logic                 active_o,
  output term_t                term_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o   <= '0;
      active_o <= 1'b1;
      term_o   <= TERM_DRIVEN;
    end else if (frame_ok) begin
      unique case (op)
        OP_LOAD: begin
          code_o   <= data;
          active_o <= 1'b1;
          term_o   <= TERM_DRIVEN;
        end
        OP_WAKE: begin
          active_o <= 1'b1;
          term_o   <= TERM_DRIVEN;
        end
        OP_SLEEP: begin
          active_o <= 1'b0;
          term_o   <= term_of(data[1:0]);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/serdac_front.sv
module serdac_front
  import serdac_pkg::*;
#(
  parameter int CODE_BITS   = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n_i,
  input  logic                 sclk_i,
  input  logic                 din_i,
  output logic [CODE_BITS-1:0] code_o,
  output logic                 active_o,
  output logic [1:0]           term_o
);

  localparam int FRAME_BITS = CMD_BITS + CODE_BITS;

  logic [2:0]            pins_s;
  logic [FRAME_BITS-1:0] frame_word;
  logic                  frame_end;
  logic                  frame_full;
  logic                  frame_ok;
  logic [CMD_BITS-1:0]   frame_cmd;
  logic [CODE_BITS-1:0]  frame_data;
  op_t                   frame_op;
  term_t                 term_q;

  serdac_sync #(
    .WIDTH    (3),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(3'b100)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({cs_n_i, sclk_i, din_i}),
    .sync_o (pins_s)
  );

  serdac_deser #(
    .FRAME_BITS(FRAME_BITS)
  ) u_deser (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_s      (pins_s[2]),
    .sclk_s      (pins_s[1]),
    .din_s       (pins_s[0]),
    .word_o      (frame_word),
    .frame_end_o (frame_end),
    .frame_full_o(frame_full)
  );

  assign frame_cmd  = frame_word[FRAME_BITS-1 -: CMD_BITS];
  assign frame_data = frame_word[CODE_BITS-1:0];
  assign frame_op   = decode_op(frame_cmd, frame_data[1:0]);
  assign frame_ok   = frame_end & frame_full;

  serdac_ctrl #(
    .CODE_BITS(CODE_BITS)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_ok(frame_ok),
    .op      (frame_op),
    .data    (frame_data),
    .code_o  (code_o),
    .active_o(active_o),
    .term_o  (term_q)
  );

  assign term_o = term_q;

endmodule

// File: rtl/serdac_front_chk.sv
module serdac_front_chk
  import serdac_pkg::*;
#(
  parameter int CODE_BITS = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frame_end,
  input logic                 frame_ok,
  input op_t                  frame_op,
  input logic [CODE_BITS-1:0] frame_data,
  input logic [CODE_BITS-1:0] code_o,
  input logic                 active_o,
  input logic [1:0]           term_o
);

  AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && frame_op == OP_LOAD |=> active_o && term_o == 2'b00 && code_o == $past(frame_data)); // R2

  AST_WAKE_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && frame_op == OP_WAKE |=> active_o && $stable(code_o)); // R3

  AST_SLEEP_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && frame_op == OP_SLEEP |=> !active_o && $stable(code_o) && term_o == $past(frame_data[1:0])); // R5

  AST_BAD_LENGTH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && !frame_ok |=> $stable(code_o) && $stable(active_o) && $stable(term_o)); // R8

  AST_UNKNOWN_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && frame_op == OP_NONE |=> $stable(code_o) && $stable(active_o) && $stable(term_o)); // R9

  AST_NO_FRAME_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> $stable(code_o) && $stable(active_o) && $stable(term_o)); // R7

  AST_ACTIVE_MATCHES_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    active_o == (term_o == 2'b00)); // R10

endmodule

bind serdac_front serdac_front_chk #(.CODE_BITS(CODE_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_end (frame_end),
  .frame_ok  (frame_ok),
  .frame_op  (frame_op),
  .frame_data(frame_data),
  .code_o    (code_o),
  .active_o  (active_o),
  .term_o    (term_o)
);

// File: tb/test_serdac_front.sv
`timescale 1ns/1ps
module test_serdac_front;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic [11:0] code;
  logic        active;
  logic [1:0]  term;

  int checks = 0;
  int errors = 0;

  logic [11:0] exp_code;
  logic        exp_active;
  logic [1:0]  exp_term;

  always #5 clk = ~clk;

  serdac_front i_serdac_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n_i  (cs_n),
    .sclk_i  (sclk),
    .din_i   (din),
    .code_o  (code),
    .active_o(active),
    .term_o  (term)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req);
    checks++;
    if (code !== exp_code || active !== exp_active || term !== exp_term) begin
      errors++;
      $display("FAIL %s: code=%h active=%b term=%b expected code=%h active=%b term=%b",
               req, code, active, term, exp_code, exp_active, exp_term);
    end
  endtask

  // Shift nbits of word out, MSB first; data valid before each falling edge.
  task automatic send_bits(input logic [31:0] word, input int nbits);
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      din  = word[i];
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
      wait_clk(4);
    end
    wait_clk(2);
    cs_n = 1'b1;
    wait_clk(8);
  endtask

  // Independent model of the command table.
  task automatic model(input logic [3:0] cmd, input logic [11:0] data);
    if (cmd == 4'd0) begin
      exp_code = data; exp_active = 1'b1; exp_term = 2'b00;
    end else if (cmd == 4'd15) begin
      if (data % 4 == 0) begin
        exp_active = 1'b1; exp_term = 2'b00;
      end else begin
        exp_active = 1'b0; exp_term = 2'(data % 4);
      end
    end
  endtask

  task automatic frame(input logic [3:0] cmd, input logic [11:0] data, input string req);
    send_bits({16'h0, cmd, data}, 16);
    model(cmd, data);
    check(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    exp_code = 12'h000; exp_active = 1'b1; exp_term = 2'b00;
    wait_clk(3);
    check("R6 reset state");
    rst_n = 1'b1;
    wait_clk(4);
    check("R6 after reset release");

    // R1 R2: load sweep across the code range, including both ends.
    for (int v = 0; v < 4096; v += 37) frame(4'h0, 12'(v), "R1 R2 load sweep");
    frame(4'h0, 12'hFFF, "R2 load full scale");
    frame(4'h0, 12'h000, "R2 load zero");
    frame(4'h0, 12'h800, "R1 MSB of data");
    frame(4'h0, 12'h001, "R1 LSB of data");

    // R3 R4 R5 R9: every command against every termination pattern,
    // from powered and from powered-down start states.
    for (int c = 0; c < 16; c++) begin
      for (int lo = 0; lo < 4; lo++) begin
        for (int st = 0; st < 2; st++) begin
          frame(4'h0, 12'h5A0 + 12'(c), "R2 setup");
          if (st == 1) frame(4'hF, 12'h002, "R5 setup sleep");
          frame(4'(c), 12'hC30 | 12'(lo),
                (c == 0) ? "R2 command sweep" :
                (c != 15) ? "R9 unknown command" :
                (lo == 0) ? "R3 wake keeps code" :
                (lo == 1) ? "R4 sleep floating" : "R5 sleep resistor");
        end
      end
    end

    // R3: wake with upper data bits set restores held code.
    frame(4'h0, 12'h3E7, "R2 setup");
    frame(4'hF, 12'h003, "R5 sleep 100k");
    frame(4'hF, 12'hFFC, "R3 wake ignores bits 11..2");
    frame(4'hF, 12'h001, "R4 sleep floating");
    frame(4'h0, 12'h456, "R2 load while asleep wakes");

    // R7: clock activity with select high changes nothing.
    din = 1'b0;
    for (int i = 0; i < 20; i++) begin
      sclk = 1'b1; wait_clk(4);
      sclk = 1'b0; wait_clk(4);
    end
    check("R7 clocks with select high");
    frame(4'hF, 12'h002, "R7 next frame framed correctly");
    frame(4'h0, 12'h456, "R7 recover");

    // R8: short frames that would otherwise load, long frames ending in a load.
    for (int n = 1; n < 16; n++) begin
      send_bits({16'h0, 4'h0, 12'hABC} >> (16 - n), n);
      check("R8 short frame ignored");
    end
    for (int n = 17; n <= 20; n++) begin
      send_bits({16'h0, 4'h0, 12'h9D1}, n);
      check("R8 long frame ignored");
    end
    send_bits(32'h0, 0);
    check("R8 empty frame ignored");
    frame(4'h0, 12'h9D1, "R8 exact frame after bad ones");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule